// File: doc/BRIEF.md
# Configurable Macrocell Register Slice

This block is a group of register cells shaped like the storage element of a programmable-logic macrocell. Each cell holds one bit. Static configuration chooses the cell's clock, its clock enable, and how it responds to set and reset. A small clock generator shared by the group turns the global clock inputs into four block clocks. Each block clock is either the true or the complemented form of a chosen global clock.

Every cell receives its own clock term, enable term, set term, reset term and data bit. All cells also share a clock term, a group-wide initialization term and a power-on reset. Set and reset are asynchronous. A per-cell swap option exchanges the roles of set and reset, and it also fixes the value the cell takes at power-up. The block has no streaming data path, so every pin is a plain level or clock signal with no handshake.

Top module: `mcell_slice`

## Requirements
- R1: Block clock k equals global clock `BCLK_SRC[k]` XOR `BCLK_POL[k]`. A set polarity bit takes the complement.
- R2: The 3-bit clock select of a cell is coded as follows: 0 to 3 select block clock 0 to 3, 4 selects the cell clock term, 5 selects its inverse, 6 selects the shared clock term, and 7 selects a constant low, so the cell is never clocked.
- R3: The 2-bit enable select of a cell is coded as follows: 0 selects the cell enable term, 1 selects its inverse, 2 selects the shared clock term, and 3 selects a constant high.
- R4: On a rising edge of its selected clock, a cell loads its data bit if the selected enable is 1. Otherwise it keeps its value.
- R5: The group initialization term acts only on cells whose init-used bit is set. It acts as a reset when the swap bit is 0 and as a set when the swap bit is 1.
- R6: The cell set term drives 1 and the cell reset term drives 0. When the swap bit is 1, the two terms exchange roles.
- R7: When both the effective set and the effective reset are active, the cell output is 0.
- R8: Set and reset take effect without any clock edge and hold while they are active.
- R9: While power-on reset is high, a cell outputs its power-up value and ignores clocks, data, and the set and reset terms. The power-up value is 1 only when both swap and init-used are set, and 0 otherwise.
- R10: After power-on reset is released, a cell keeps its power-up value until a clock, set or reset event changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pwr_on_rst | input | 1 | Power-on reset, active high |
| glob_clk | input | NGCLK | Global clock inputs to the clock generator |
| shr_clk_term | input | 1 | Clock term shared by all cells |
| grp_init_term | input | 1 | Group-wide initialization term |
| cell_clk_term | input | NCELL | Per-cell clock term |
| cell_ce_term | input | NCELL | Per-cell enable term |
| cell_set_term | input | NCELL | Per-cell set term |
| cell_rst_term | input | NCELL | Per-cell reset term |
| cell_d | input | NCELL | Per-cell data bit |
| cell_q | output | NCELL | Per-cell registered output |

## Verification
The bench builds the slice with eight cells. Each cell uses a different clock select code from 0 to 7, and all four enable codes appear among the cells. The swap and init-used bits are spread so that some cells power up to 1 and others to 0. The clock generator maps sources in reverse order and inverts two of the four block clocks, so both polarities and a non-trivial source mapping are exercised. A reference model in the bench tracks every cell while the sweep steps each clock line, every enable pattern and several data patterns. The sweep then drives the asynchronous terms one at a time, in overlapping combinations, and during power-on reset.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  localparam int NBCLK = 4;

  typedef enum logic [2:0] {
    CK_BLK0   = 3'd0,
    CK_BLK1   = 3'd1,
    CK_BLK2   = 3'd2,
    CK_BLK3   = 3'd3,
    CK_TERM   = 3'd4,
    CK_TERM_N = 3'd5,
    CK_SHARED = 3'd6,
    CK_OFF    = 3'd7
  } clk_src_e;

  typedef enum logic [1:0] {
    CE_TERM   = 2'd0,
    CE_TERM_N = 2'd1,
    CE_SHARED = 2'd2,
    CE_ON     = 2'd3
  } ce_src_e;

  function automatic logic pu_value(logic swap, logic init_used);
    return swap & init_used;
  endfunction

endpackage

// File: rtl/mcell_clkgen.sv
module mcell_clkgen #(
  parameter int NGCLK = 4,
  parameter int SRC_W = (NGCLK > 1) ? $clog2(NGCLK) : 1,
  parameter logic [mcell_pkg::NBCLK*SRC_W-1:0] BCLK_SRC = '0,
  parameter logic [mcell_pkg::NBCLK-1:0] BCLK_POL = '0
) (
  input  logic [NGCLK-1:0]            glob_clk,
  output logic [mcell_pkg::NBCLK-1:0] blk_clk
);

  for (genvar k = 0; k < mcell_pkg::NBCLK; k++) begin : g_bclk
    localparam int SRC = int'(BCLK_SRC[k*SRC_W +: SRC_W]);
    if (SRC >= NGCLK) begin : g_bad
      $error("block clock source index out of range");
    end
    if (BCLK_POL[k]) begin : g_inv
      assign blk_clk[k] = ~glob_clk[SRC];
    end else begin : g_true
      assign blk_clk[k] = glob_clk[SRC];
    end
  end

endmodule

// File: rtl/mcell_sel.sv
module mcell_sel #(
  parameter logic [2:0] CSEL = 3'd0,
  parameter logic [1:0] ESEL = 2'd3
) (
  input  logic [mcell_pkg::NBCLK-1:0] blk_clk,
  input  logic                        term_clk,
  input  logic                        term_ce,
  input  logic                        shr_clk,
  output logic                        sel_clk,
  output logic                        sel_ce
);
  import mcell_pkg::*;

  localparam clk_src_e CK = clk_src_e'(CSEL);
  localparam ce_src_e  CE = ce_src_e'(ESEL);

  always_comb begin
    case (CK)
      CK_BLK0:   sel_clk = blk_clk[0];
      CK_BLK1:   sel_clk = blk_clk[1];
      CK_BLK2:   sel_clk = blk_clk[2];
      CK_BLK3:   sel_clk = blk_clk[3];
      CK_TERM:   sel_clk = term_clk;
      CK_TERM_N: sel_clk = ~term_clk;
      CK_SHARED: sel_clk = shr_clk;
      default:   sel_clk = 1'b0;
    endcase
  end

  always_comb begin
    case (CE)
      CE_TERM:   sel_ce = term_ce;
      CE_TERM_N: sel_ce = ~term_ce;
      CE_SHARED: sel_ce = shr_clk;
      default:   sel_ce = 1'b1;
    endcase
  end

endmodule

// File: rtl/mcell_initctl.sv
module mcell_initctl #(
  parameter logic SWAP      = 1'b0,
  parameter logic INIT_USED = 1'b0
) (
  input  logic por,
  input  logic grp_init,
  input  logic set_term,
  input  logic rst_term,
  output logic set_eff,
  output logic rst_eff,
  output logic async_clr,
  output logic async_pre
);
  import mcell_pkg::*;

  localparam logic PU = pu_value(SWAP, INIT_USED);

  logic raw_rst;
  logic raw_set;

  assign raw_rst = (INIT_USED & grp_init) | rst_term;
  assign raw_set = set_term;

  if (SWAP) begin : g_swap
    assign rst_eff = raw_set;
    assign set_eff = raw_rst;
  end else begin : g_plain
    assign rst_eff = raw_rst;
    assign set_eff = raw_set;
  end

  always_comb begin
    if (por) begin
      async_clr = ~PU;
      async_pre = PU;
    end else begin
      async_clr = rst_eff;
      async_pre = set_eff & ~rst_eff;
    end
  end

endmodule

// File: rtl/mcell_ff.sv
module mcell_ff #(
  parameter logic PU     = 1'b0,
  parameter bit   NO_CLK = 1'b0
) (
  input  logic clk,
  input  logic ce,
  input  logic d,
  input  logic async_clr,
  input  logic async_pre,
  input  logic por,
  input  logic set_eff,
  input  logic rst_eff,
  input  logic chk_clk,
  output logic q
);

  always_ff @(posedge clk or posedge async_clr or posedge async_pre) begin
    if (async_clr)      q <= 1'b0;
    else if (async_pre) q <= 1'b1;
    else if (ce)        q <= d;
  end

  // R7
  rst_dom_chk: assert property (@(posedge chk_clk) disable iff (por)
    rst_eff |-> !q);

  // R6
  set_hold_chk: assert property (@(posedge chk_clk) disable iff (por)
    (set_eff && !rst_eff) |-> q);

  // R9
  always @(negedge chk_clk) begin
    if (por) begin
      por_hold_chk: assert (q == PU);
    end
  end

  if (NO_CLK) begin : g_off
    // R2
    off_clk_chk: assert property (@(posedge chk_clk) disable iff (por)
      (!set_eff && !rst_eff && $past(!set_eff && !rst_eff)) |-> $stable(q));
  end

endmodule

// File: rtl/mcell_slice.sv
module mcell_slice #(
  parameter int NCELL = 4,
  parameter int NGCLK = 4,
  parameter int SRC_W = (NGCLK > 1) ? $clog2(NGCLK) : 1,
  parameter logic [NCELL*3-1:0] CLK_SEL   = 12'o3210,
  parameter logic [NCELL*2-1:0] EN_SEL    = '1,
  parameter logic [NCELL-1:0]   SWAP      = '0,
  parameter logic [NCELL-1:0]   INIT_USED = '1,
  parameter logic [mcell_pkg::NBCLK*SRC_W-1:0] BCLK_SRC = 8'b11_10_01_00,
  parameter logic [mcell_pkg::NBCLK-1:0]       BCLK_POL = '0
) (
  input  logic             pwr_on_rst,
  input  logic [NGCLK-1:0] glob_clk,
  input  logic             shr_clk_term,
  input  logic             grp_init_term,
  input  logic [NCELL-1:0] cell_clk_term,
  input  logic [NCELL-1:0] cell_ce_term,
  input  logic [NCELL-1:0] cell_set_term,
  input  logic [NCELL-1:0] cell_rst_term,
  input  logic [NCELL-1:0] cell_d,
  output logic [NCELL-1:0] cell_q
);
  import mcell_pkg::*;

  logic [NBCLK-1:0] blk_clk;

  mcell_clkgen #(
    .NGCLK(NGCLK), .SRC_W(SRC_W), .BCLK_SRC(BCLK_SRC), .BCLK_POL(BCLK_POL)
  ) u_clkgen (
    .glob_clk(glob_clk),
    .blk_clk (blk_clk)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    localparam logic [2:0] CS = CLK_SEL[i*3 +: 3];
    localparam logic [1:0] ES = EN_SEL[i*2 +: 2];
    localparam logic       PU = pu_value(SWAP[i], INIT_USED[i]);

    logic sel_clk, sel_ce, set_eff, rst_eff, a_clr, a_pre;

    mcell_sel #(.CSEL(CS), .ESEL(ES)) u_sel (
      .blk_clk (blk_clk),
      .term_clk(cell_clk_term[i]),
      .term_ce (cell_ce_term[i]),
      .shr_clk (shr_clk_term),
      .sel_clk (sel_clk),
      .sel_ce  (sel_ce)
    );

    mcell_initctl #(.SWAP(SWAP[i]), .INIT_USED(INIT_USED[i])) u_init (
      .por      (pwr_on_rst),
      .grp_init (grp_init_term),
      .set_term (cell_set_term[i]),
      .rst_term (cell_rst_term[i]),
      .set_eff  (set_eff),
      .rst_eff  (rst_eff),
      .async_clr(a_clr),
      .async_pre(a_pre)
    );

    mcell_ff #(.PU(PU), .NO_CLK(CS == 3'd7)) u_ff (
      .clk      (sel_clk),
      .ce       (sel_ce),
      .d        (cell_d[i]),
      .async_clr(a_clr),
      .async_pre(a_pre),
      .por      (pwr_on_rst),
      .set_eff  (set_eff),
      .rst_eff  (rst_eff),
      .chk_clk  (glob_clk[0]),
      .q        (cell_q[i])
    );
  end

endmodule

// File: tb/mcell_slice_test.sv
`timescale 1ns/100ps
module mcell_slice_test;

  localparam int NC = 8;
  localparam logic [NC*3-1:0] CSEL  = 24'o76543210;
  localparam logic [NC*2-1:0] ESEL  = 16'hF4E4;
  localparam logic [NC-1:0]   SWP   = 8'hF0;
  localparam logic [NC-1:0]   IUSE  = 8'hAA;
  localparam logic [7:0]      BSRC  = 8'b00_01_10_11;
  localparam logic [3:0]      BPOL  = 4'b0101;
  localparam logic [NC-1:0]   PUV   = SWP & IUSE;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          por = 1'b0;
  logic [3:0]    gclk = '0;
  logic          shr = 1'b0;
  logic          binit = 1'b0;
  logic [NC-1:0] ptclk = '0, ptce = '0, cset = '0, crst = '0, d = '0;
  logic [NC-1:0] q;
  logic [NC-1:0] exp_q = '0;
  int checks = 0, fails = 0;

  mcell_slice #(
    .NCELL(NC), .NGCLK(4), .CLK_SEL(CSEL), .EN_SEL(ESEL), .SWAP(SWP),
    .INIT_USED(IUSE), .BCLK_SRC(BSRC), .BCLK_POL(BPOL)
  ) uut (
    .pwr_on_rst(por), .glob_clk(gclk), .shr_clk_term(shr),
    .grp_init_term(binit), .cell_clk_term(ptclk), .cell_ce_term(ptce),
    .cell_set_term(cset), .cell_rst_term(crst), .cell_d(d), .cell_q(q)
  );

  function automatic logic bclk_m(int k);
    return gclk[BSRC[k*2 +: 2]] ^ BPOL[k];
  endfunction

  function automatic logic clk_m(int i);
    case (CSEL[i*3 +: 3])
      3'd0, 3'd1, 3'd2, 3'd3: return bclk_m(int'(CSEL[i*3 +: 3]));
      3'd4: return ptclk[i];
      3'd5: return ~ptclk[i];
      3'd6: return shr;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ce_m(int i);
    case (ESEL[i*2 +: 2])
      2'd0: return ptce[i];
      2'd1: return ~ptce[i];
      2'd2: return shr;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic rrst_m(int i);
    return (IUSE[i] & binit) | crst[i];
  endfunction

  function automatic logic rst_m(int i);
    return SWP[i] ? cset[i] : rrst_m(i);
  endfunction

  function automatic logic set_m(int i);
    return SWP[i] ? rrst_m(i) : cset[i];
  endfunction

  task automatic check(input string tag);
    checks++;
    if (q !== exp_q) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, q, exp_q);
    end
  endtask

  task automatic step(input int kind, input logic [7:0] val, input string tag);
    logic [NC-1:0] oc;
    @(negedge clk);
    for (int i = 0; i < NC; i++) oc[i] = clk_m(i);
    case (kind)
      0: por   = val[0];
      1: gclk  = val[3:0];
      2: shr   = val[0];
      3: binit = val[0];
      4: ptclk = val;
      5: ptce  = val;
      6: cset  = val;
      7: crst  = val;
      default: d = val;
    endcase
    #1;
    for (int i = 0; i < NC; i++) begin
      if (!oc[i] && clk_m(i) && ce_m(i) && !por) exp_q[i] = d[i];
      if (por)           exp_q[i] = PUV[i];
      else if (rst_m(i)) exp_q[i] = 1'b0;
      else if (set_m(i)) exp_q[i] = 1'b1;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] dpats [4];
    dpats[0] = 8'hFF; dpats[1] = 8'h00; dpats[2] = 8'hA5; dpats[3] = 8'h5A;

    // R9: power-up values, then clocks, data and async terms ignored
    step(0, 8'h01, "R9 power-up");
    step(8, 8'hFF, "R9 data ignored");
    for (int k = 0; k < 4; k++) begin
      step(1, 8'(1 << k), "R9 clock ignored");
      step(1, 8'h00, "R9 clock ignored");
    end
    step(4, 8'hFF, "R9 term clock ignored");
    step(4, 8'h00, "R9 term clock ignored");
    step(2, 8'h01, "R9 shared clock ignored");
    step(2, 8'h00, "R9 shared clock ignored");
    step(6, 8'hFF, "R9 set ignored");
    step(6, 8'h00, "R9 set ignored");
    step(7, 8'hFF, "R9 reset ignored");
    step(7, 8'h00, "R9 reset ignored");
    step(3, 8'h01, "R9 init ignored");
    step(3, 8'h00, "R9 init ignored");
    step(0, 8'h00, "R10 release keeps power-up value");

    // R1 R2 R3 R4: sweep every clock line under each enable pattern
    for (int p = 0; p < 4; p++) begin
      step(8, dpats[p], "R4 data change alone");
      for (int c = 0; c < 2; c++) begin
        step(5, c ? 8'hFF : 8'h00, "R3 enable term");
        for (int s = 0; s < 2; s++) begin
          step(2, 8'(s), "R2 R3 shared clock");
          for (int k = 0; k < 4; k++) begin
            step(1, 8'(1 << k), "R1 R2 R4 block clock");
            step(1, 8'h00, "R1 R2 R4 block clock");
          end
          step(4, 8'hFF, "R2 R4 term clock");
          step(4, 8'h00, "R2 R4 term clock");
        end
      end
    end

    // R5 R6 R7 R8: asynchronous terms, no clock activity
    step(3, 8'h01, "R5 R8 group init");
    step(3, 8'h00, "R5 R8 group init release");
    step(6, 8'hFF, "R6 R8 set terms");
    step(7, 8'hFF, "R7 R8 both active");
    step(6, 8'h00, "R6 R8 reset terms only");
    step(7, 8'h00, "R6 R8 release");
    step(8, 8'h00, "R8 data only");
    step(6, 8'h20, "R6 swapped set term");
    step(3, 8'h01, "R7 init with swapped set term");
    step(6, 8'h00, "R5 init alone");
    step(3, 8'h00, "R5 release");
    step(7, 8'h0F, "R6 reset terms low cells");
    step(7, 8'h00, "R6 release");

    // R9 R10: power-on reset reapplied mid-run
    step(0, 8'h01, "R9 reapply");
    step(0, 8'h00, "R10 release");
    step(8, 8'h3C, "R10 data alone");
    step(1, 8'h08, "R10 block clock");
    step(1, 8'h00, "R4 block clock");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule